// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front-End

This block is the device side of a parallel NOR-style memory bus. Its inputs are the active-low chip-enable, output-enable and write-enable pins, a byte-select pin, a word address and the incoming data pins. Its outputs are a data value plus a per-pin drive-enable vector. The pad ring combines the two into real tri-state pins. Reads are served from a four-word page buffer that sits in front of a small word array. Write cycles are not decoded: each one is reported as a single strobe to a separate command block, together with the address and data captured at the start of the cycle.

All pins are sampled on the rising clock edge, and every output reflects the pins sampled one edge earlier. When the byte-select pin is high, the bus is 16 bits wide. When it is low, only the lower eight data pins are driven, and the top data pin becomes an extra least-significant address input that picks a byte within the addressed word. After reset the block is in read-array state, so reads return array contents with no command issued first. The array is filled through a back-door load port.

Top module: `nor_bus_frontend`

## Requirements
- R1: While reset is high and on the cycle after it, `dq_oe` is all zero, `dq_out` is zero and `wr_strobe` is low.
- R2: A read cycle is `ce_n`=0, `oe_n`=0, `we_n`=1. If it is sampled with `byte_n`=1, then after the next edge `dq_oe`=16'hFFFF and `dq_out` equals the 16-bit array word at `addr`.
- R3: If a read cycle is sampled with `byte_n`=0, then after the next edge `dq_oe`=16'h00FF and `dq_out[15:8]`=0.
- R4: In byte mode, the value sampled on `dq_in[15]` picks the byte: 0 places word bits 7:0 on `dq_out[7:0]`, and 1 places word bits 15:8 there.
- R5: If the pins sampled show `ce_n`=1, `oe_n`=1, or `we_n`=0, then after the next edge `dq_oe` is all zero and `dq_out` is zero. This includes the case where `oe_n` and `we_n` are both low.
- R6: After reset, read cycles return array contents without any prior command sequence.
- R7: `addr[ADDR_W-1:2]` selects a page and `addr[1:0]` selects the word within it. Successive reads within a page, reads across pages, and reads after `ce_n` has been high all return the addressed word, each one cycle after sampling.
- R8: A write cycle is `ce_n`=0, `we_n`=0, `oe_n`=1. `wr_strobe` goes high for exactly one cycle, one edge after a write cycle is first sampled, and stays low while that write cycle is held.
- R9: While `wr_strobe` is high, `wr_addr` is `{addr, dq_in[15]}` in byte mode and `{addr, 1'b0}` in word mode. `wr_data` is `dq_in` in word mode and `{8'h00, dq_in[7:0]}` in byte mode, both taken from the cycle's first sample.
- R10: A back-door load (`ld_en`=1) writes `ld_data` to word `ld_addr`. Reads sampled in any later cycle return the new value, even when that word's page is currently held in the page buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | 1 = word mode, 0 = byte mode |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data pins as seen by the block; bit 15 is the byte address in byte mode |
| dq_out | output | 16 | Value to drive on the data pins |
| dq_oe | output | 16 | Per-pin drive enable |
| wr_strobe | output | 1 | One-cycle pulse per write cycle |
| wr_addr | output | ADDR_W+1 | Byte address of the reported write |
| wr_data | output | 16 | Data of the reported write |
| ld_en | input | 1 | Back-door array load enable |
| ld_addr | input | ADDR_W | Back-door load word address |
| ld_data | input | 16 | Back-door load data |

## Verification
The bench targets the byte-lane corner cases. It reads with `dq_in[15]` at both values in byte mode to catch swapped halves or an upper lane left driven. It then flips `byte_n` between reads of the same word, so that stale mode state would show up as a wrong drive-enable pattern. It holds `oe_n` and `we_n` low together: a decoder that treated that as a read would drive the bus. It holds a write cycle for several cycles: a level-based strobe would pulse repeatedly. Finally, it loads a word whose page is already buffered while chip-enable stays low, and then reads that word back; a buffer that missed the update would return the old data.

// File: rtl/nor_fe_pkg.sv
package nor_fe_pkg;

    localparam int WORD_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int PAGE_WORDS = 4;
    localparam int OFF_W      = $clog2(PAGE_WORDS);

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } bus_cyc_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic byte_n;
    } ctrl_pins_t;

    typedef struct packed {
        bus_cyc_e cyc;
        logic     byte_mode;
        logic     lo_addr;
    } bus_req_t;

    function automatic bus_cyc_e classify(input ctrl_pins_t p);
        if (p.ce_n)
            return CYC_IDLE;
        else if (!p.oe_n && p.we_n)
            return CYC_READ;
        else if (p.oe_n && !p.we_n)
            return CYC_WRITE;
        else
            return CYC_IDLE;
    endfunction

    function automatic logic [WORD_W-1:0] lane_pick(input logic [WORD_W-1:0] w,
                                                    input logic byte_mode,
                                                    input logic hi_sel);
        if (!byte_mode)
            return w;
        return {{(WORD_W-BYTE_W){1'b0}}, hi_sel ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0]};
    endfunction

endpackage

// File: rtl/nor_fe_decode.sv
module nor_fe_decode
    import nor_fe_pkg::*;
(
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              byte_n,
    input  logic              dq_top,
    output bus_req_t          req
);
    ctrl_pins_t pins;

    always_comb begin
        pins          = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, byte_n: byte_n};
        req.cyc       = classify(pins);
        req.byte_mode = !byte_n;
        req.lo_addr   = !byte_n && dq_top;
    end
endmodule

// File: rtl/nor_fe_array.sv
module nor_fe_array
    import nor_fe_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              ld_en,
    input  logic [ADDR_W-1:0]                 ld_addr,
    input  logic [WORD_W-1:0]                 ld_data,
    input  logic [ADDR_W-OFF_W-1:0]           page_sel,
    output logic [PAGE_WORDS-1:0][WORD_W-1:0] page_words
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end
    end

    for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_page_rd
        assign page_words[g] = mem[{page_sel, OFF_W'(g)}];
    end
endmodule

// File: rtl/nor_fe_pagebuf.sv
module nor_fe_pagebuf
    import nor_fe_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  bus_req_t                          req,
    input  logic                              chip_sel,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [PAGE_WORDS-1:0][WORD_W-1:0] page_words,
    input  logic                              ld_en,
    input  logic [ADDR_W-1:0]                 ld_addr,
    input  logic [WORD_W-1:0]                 ld_data,
    output logic [WORD_W-1:0]                 dq_out,
    output logic [WORD_W-1:0]                 dq_oe
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic                              buf_valid;
    logic [PAGE_W-1:0]                 buf_tag;
    logic [PAGE_WORDS-1:0][WORD_W-1:0] buf_words;
    logic                              rd_q;
    logic                              byte_q;
    logic                              hi_q;
    logic [OFF_W-1:0]                  off_q;

    logic [PAGE_W-1:0] req_page;
    logic [PAGE_W-1:0] ld_page;
    logic [OFF_W-1:0]  ld_off;
    logic              is_read;
    logic              miss;

    assign req_page = addr[ADDR_W-1:OFF_W];
    assign ld_page  = ld_addr[ADDR_W-1:OFF_W];
    assign ld_off   = ld_addr[OFF_W-1:0];
    assign is_read  = (req.cyc == CYC_READ);
    assign miss     = is_read && (!buf_valid || buf_tag != req_page);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_valid <= 1'b0;
            buf_tag   <= '0;
            buf_words <= '0;
            rd_q      <= 1'b0;
            byte_q    <= 1'b0;
            hi_q      <= 1'b0;
            off_q     <= '0;
        end else begin
            rd_q <= is_read;
            if (is_read) begin
                byte_q <= req.byte_mode;
                hi_q   <= req.lo_addr;
                off_q  <= addr[OFF_W-1:0];
            end
            if (!chip_sel) begin
                buf_valid <= 1'b0;
            end else if (miss) begin
                buf_valid <= 1'b1;
                buf_tag   <= req_page;
                for (int i = 0; i < PAGE_WORDS; i++) begin
                    if (ld_en && ld_page == req_page && ld_off == OFF_W'(i))
                        buf_words[i] <= ld_data;
                    else
                        buf_words[i] <= page_words[i];
                end
            end else if (buf_valid && ld_en && ld_page == buf_tag) begin
                buf_words[ld_off] <= ld_data;
            end
        end
    end

    always_comb begin
        dq_out = '0;
        dq_oe  = '0;
        if (rd_q) begin
            dq_out = lane_pick(buf_words[off_q], byte_q, hi_q);
            dq_oe  = byte_q ? {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} : {WORD_W{1'b1}};
        end
    end
endmodule

// File: rtl/nor_fe_wrcap.sv
module nor_fe_wrcap
    import nor_fe_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] dq_in,
    output logic              wr_strobe,
    output logic [ADDR_W:0]   wr_addr,
    output logic [WORD_W-1:0] wr_data
);
    logic in_write;
    logic was_write;

    assign in_write = (req.cyc == CYC_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            was_write <= 1'b0;
            wr_strobe <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            was_write <= in_write;
            wr_strobe <= in_write && !was_write;
            if (in_write && !was_write) begin
                wr_addr <= {addr, req.lo_addr};
                wr_data <= lane_pick(dq_in, req.byte_mode, 1'b0);
            end
        end
    end
endmodule

// File: rtl/nor_bus_frontend.sv
module nor_bus_frontend
    import nor_fe_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              byte_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic              wr_strobe,
    output logic [ADDR_W:0]   wr_addr,
    output logic [15:0]       wr_data,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [15:0]       ld_data
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    bus_req_t                          req;
    logic [PAGE_W-1:0]                 page_sel;
    logic [PAGE_WORDS-1:0][WORD_W-1:0] page_words;

    assign page_sel = addr[ADDR_W-1:OFF_W];

    nor_fe_decode u_decode (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .byte_n (byte_n),
        .dq_top (dq_in[WORD_W-1]),
        .req    (req)
    );

    nor_fe_array #(.ADDR_W(ADDR_W)) u_array (
        .clk        (clk),
        .rst        (rst),
        .ld_en      (ld_en),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .page_sel   (page_sel),
        .page_words (page_words)
    );

    nor_fe_pagebuf #(.ADDR_W(ADDR_W)) u_pagebuf (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .chip_sel   (!ce_n),
        .addr       (addr),
        .page_words (page_words),
        .ld_en      (ld_en),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    nor_fe_wrcap #(.ADDR_W(ADDR_W)) u_wrcap (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .addr      (addr),
        .dq_in     (dq_in),
        .wr_strobe (wr_strobe),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );
endmodule

// File: rtl/nor_fe_chk.sv
module nor_fe_chk #(
    parameter int ADDR_W = 5
) (
    input logic        clk,
    input logic        rst,
    input logic        ce_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        byte_n,
    input logic [15:0] dq_out,
    input logic [15:0] dq_oe,
    input logic        wr_strobe,
    input logic [15:0] wr_data
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dq_oe == 16'h0 && !wr_strobe));

    // R5
    bus_float_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(ce_n) || $past(oe_n) || !$past(we_n)))
        |-> (dq_oe == 16'h0 && dq_out == 16'h0));

    // R2
    word_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ce_n) && !$past(oe_n) && $past(we_n) && $past(byte_n))
        |-> dq_oe == 16'hFFFF);

    // R3
    byte_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ce_n) && !$past(oe_n) && $past(we_n) && !$past(byte_n))
        |-> (dq_oe == 16'h00FF && dq_out[15:8] == 8'h00));

    // R8
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (!$past(ce_n) && !$past(we_n) && $past(oe_n)));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);

    // R9
    byte_wdata_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && !$past(byte_n)) |-> wr_data[15:8] == 8'h00);
endmodule

bind nor_bus_frontend nor_fe_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .byte_n    (byte_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .wr_strobe (wr_strobe),
    .wr_data   (wr_data)
);

// File: tb/nor_bus_frontend_test.sv
module nor_bus_frontend_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out, dq_oe, wr_data;
    logic          wr_strobe;
    logic [AW:0]   wr_addr;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [15:0]   ld_data = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] model [DEPTH];
    bit          prev_wr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_bus_frontend #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .byte_n(byte_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One bus cycle: drive at negedge, expect outputs one edge later.
    task automatic bus(input bit ce, input bit oe, input bit we, input bit bn,
                       input logic [AW-1:0] a, input logic [15:0] d, input string tag);
        logic [15:0] e_out, e_oe, e_wd, w;
        logic [AW:0] e_wa;
        bit rd, wr, e_st;
        ce_n = ce; oe_n = oe; we_n = we; byte_n = bn; addr = a; dq_in = d;
        rd = !ce && !oe && we;
        wr = !ce && oe && !we;
        e_out = 16'h0; e_oe = 16'h0;
        if (rd) begin
            w = model[a];
            if (bn) begin e_out = w; e_oe = 16'hFFFF; end
            else begin e_out = {8'h00, d[15] ? w[15:8] : w[7:0]}; e_oe = 16'h00FF; end
        end
        e_st = wr && !prev_wr;
        e_wa = {a, bn ? 1'b0 : d[15]};
        e_wd = bn ? d : {8'h00, d[7:0]};
        @(posedge clk);
        prev_wr = wr;
        @(negedge clk);
        check(dq_oe == e_oe, tag, "dq_oe", 32'(dq_oe), 32'(e_oe));
        check(dq_out == e_out, tag, "dq_out", 32'(dq_out), 32'(e_out));
        check(wr_strobe == e_st, tag, "wr_strobe", 32'(wr_strobe), 32'(e_st));
        if (e_st) begin
            check(wr_addr == e_wa, tag, "wr_addr", 32'(wr_addr), 32'(e_wa));
            check(wr_data == e_wd, tag, "wr_data", 32'(wr_data), 32'(e_wd));
        end
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [15:0] d, input bit ce);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        ce_n = ce; oe_n = 1'b1; we_n = 1'b1;
        @(posedge clk);
        model[a] = d;
        prev_wr = 0;
        @(negedge clk);
        ld_en = 1'b0;
        check(dq_oe == 16'h0, "R10", "dq_oe during load", 32'(dq_oe), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R1: quiet outputs during reset
        check(dq_oe == 16'h0, "R1", "dq_oe in reset", 32'(dq_oe), 32'h0);
        check(dq_out == 16'h0, "R1", "dq_out in reset", 32'(dq_out), 32'h0);
        check(wr_strobe == 1'b0, "R1", "wr_strobe in reset", 32'(wr_strobe), 32'h0);
        rst = 1'b0;
        bus(1, 1, 1, 1, 5'd0, 16'h0, "R1");

        // Fill the array through the back door (chip deselected)
        for (int i = 0; i < DEPTH; i++)
            load(AW'(i), 16'(((i * 37 + 11) * 16'h0193) ^ 16'h5AC3), 1'b1);

        // R6: read immediately, no command
        bus(0, 0, 1, 1, 5'd13, 16'h0, "R6");
        // R2 / R7: walk a page, then cross pages
        for (int i = 0; i < 4; i++) bus(0, 0, 1, 1, AW'(8 + i), 16'h0, "R7");
        bus(0, 0, 1, 1, 5'd3, 16'h0, "R7");
        bus(0, 0, 1, 1, 5'd31, 16'h0, "R2");
        bus(0, 0, 1, 1, 5'd28, 16'h0, "R2");
        // R7: deselect, reselect in the same page
        bus(1, 0, 1, 1, 5'd29, 16'h0, "R5");
        bus(0, 0, 1, 1, 5'd29, 16'h0, "R7");

        // R3 / R4: byte lanes
        bus(0, 0, 1, 0, 5'd29, 16'h0000, "R4");
        bus(0, 0, 1, 0, 5'd29, 16'h8000, "R4");
        bus(0, 0, 1, 0, 5'd6, 16'h8000, "R3");
        bus(0, 0, 1, 1, 5'd6, 16'h8000, "R2");
        bus(0, 0, 1, 0, 5'd6, 16'h7FFF, "R4");

        // R5: floating cases
        bus(0, 1, 1, 1, 5'd6, 16'h0, "R5");
        bus(1, 0, 1, 0, 5'd6, 16'h0, "R5");
        bus(0, 0, 0, 1, 5'd6, 16'h1234, "R5");

        // R8 / R9: held write in word mode, then byte mode
        bus(0, 1, 0, 1, 5'd17, 16'hBEEF, "R9");
        bus(0, 1, 0, 1, 5'd18, 16'h1111, "R8");
        bus(0, 1, 0, 1, 5'd19, 16'h2222, "R8");
        bus(0, 1, 1, 1, 5'd19, 16'h0, "R8");
        bus(0, 1, 0, 0, 5'd21, 16'hC35A, "R9");
        bus(1, 1, 1, 1, 5'd21, 16'h0, "R8");
        bus(0, 1, 0, 0, 5'd2, 16'h40A7, "R9");
        bus(0, 1, 1, 0, 5'd2, 16'h0, "R8");

        // R10: update a word whose page is buffered, chip held selected
        bus(0, 0, 1, 1, 5'd5, 16'h0, "R10");
        load(5'd6, 16'hD00D, 1'b0);
        bus(0, 0, 1, 1, 5'd6, 16'h0, "R10");
        load(5'd4, 16'h0F0F, 1'b0);
        bus(0, 0, 1, 0, 5'd4, 16'h8000, "R10");
        bus(0, 0, 1, 1, 5'd4, 16'h0, "R10");

        done = 1;
        report();
    end
endmodule